// File: doc/BRIEF.md
# Dual-Mode Serial Baud Rate Generator

This block supplies bit timing to a serial port. Software writes an 8-bit divisor X. A free-running down-counter reloads from that divisor, so its terminal count comes every X+1 system clocks. A prescaler then divides those terminal counts by 64 in asynchronous mode or by 4 in synchronous mode. The result is a one-clock tick at the bit rate. In synchronous master mode the block also drives a serial clock with a 50% duty cycle at the same rate.

Several events clear the counter and the prescaler at once: a write to the divisor, a change of mode, a low enable, and the synchronous slave setting. Each period then starts cleanly, and the first tick comes exactly one full period after the event. The divisor has no reset. It must be written once after power-up, and a later reset leaves it unchanged.

Top module: `baud_gen_top`

## Requirements
- R1: With sync_mode_i = 0, tick_o pulses once every 64·(X+1) clocks. The first pulse is high in the cycle after the 64·(X+1)-th clock edge that follows the clearing edge (for X = 25 that is 1664 clocks, 9615 Hz at 16 MHz).
- R2: With sync_mode_i = 1 and master_i = 1, tick_o pulses once every 4·(X+1) clocks, with the same first-pulse timing.
- R3: tick_o is never high for two consecutive cycles.
- R4: A clock edge with div_we_i = 1 stores div_wdata_i and clears the timer, whatever phase it is in. The next tick follows a full period of the new divisor, and tick_o is low in the cycle after the write.
- R5: While en_i = 0, tick_o and sclk_o stay low. After en_i rises, the first tick follows a full period counted from the first enabled edge.
- R6: A change of sync_mode_i clears the timer, so the first period in the new mode has the full length of that mode.
- R7: In synchronous master mode, sclk_o starts low after a clear. It rises 2·(X+1) clocks into each period and falls together with each tick.
- R8: sclk_o is low whenever sync_mode_i = 0.
- R9: With sync_mode_i = 1 and master_i = 0, tick_o and sclk_o stay low. Setting master_i = 1 starts a full period.
- R10: rst_ni = 0 drives tick_o and sclk_o low but keeps the divisor. After reset, one disabled clock followed by enable gives the period of the divisor written before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_wdata_i | input | 8 | Divisor write data |
| div_we_i | input | 1 | Divisor write strobe |
| sync_mode_i | input | 1 | 0 asynchronous, 1 synchronous |
| master_i | input | 1 | 1 selects synchronous clock master |
| en_i | input | 1 | Generator enable |
| tick_o | output | 1 | One-clock bit-rate pulse |
| sclk_o | output | 1 | Synchronous serial clock |

## Verification
The hardest case to reach is a clear that arrives in the middle of a period: a divisor write or a mode flip lands when the counter and prescaler sit at arbitrary nonzero values. The stimulus lets the generator run for an odd number of cycles that is not a multiple of any period, then writes or flips mode. After that it compares every following cycle against a tick and serial clock pattern that the bench derives from the new divisor alone. Sweeps over small divisors in both modes, the largest divisor and the reset-retention sequence cover the remaining corners.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int unsigned BG_DIV_W      = 8;
  localparam int unsigned BG_ASYNC_PRE  = 64;
  localparam int unsigned BG_SYNC_PRE   = 4;

  typedef enum logic {
    BG_ASYNC = 1'b0,
    BG_SYNC  = 1'b1
  } bg_mode_e;
endpackage

// File: rtl/bg_div_reg.sv
module bg_div_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] div_o,
  output logic [W-1:0] div_nxt_o
);
  logic [W-1:0] div_q;

  // no reset: value survives warm resets, undefined at power-up
  always_ff @(posedge clk_i) begin
    if (we_i) div_q <= wdata_i;
  end

  assign div_o     = div_q;
  assign div_nxt_o = we_i ? wdata_i : div_q;
endmodule

// File: rtl/bg_timer.sv
module bg_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] reload_i,
  input  logic [W-1:0] period_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= reload_i;
    else if (cnt_q == '0)     cnt_q <= period_i;
    else                      cnt_q <= cnt_q - 1'b1;
  end

  assign tc_o = (cnt_q == '0);
endmodule

// File: rtl/bg_prescale.sv
module bg_prescale #(
  parameter int unsigned ASYNC_PRE = 64,
  parameter int unsigned SYNC_PRE  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic sync_i,
  input  logic tc_i,
  output logic wrap_o,
  output logic half_o
);
  localparam int unsigned PSC_W = (ASYNC_PRE > SYNC_PRE) ? $clog2(ASYNC_PRE) : $clog2(SYNC_PRE);
  localparam logic [PSC_W-1:0] A_LAST = PSC_W'(ASYNC_PRE - 1);
  localparam logic [PSC_W-1:0] S_LAST = PSC_W'(SYNC_PRE - 1);
  localparam logic [PSC_W-1:0] S_MID  = PSC_W'(SYNC_PRE / 2 - 1);

  logic [PSC_W-1:0] psc_q;
  logic             last;

  assign last = sync_i ? (psc_q == S_LAST) : (psc_q == A_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        psc_q <= '0;
    else if (restart_i) psc_q <= '0;
    else if (tc_i)      psc_q <= last ? '0 : psc_q + 1'b1;
  end

  assign wrap_o = tc_i & last;
  // serial clock edges: middle and end of a synchronous period
  assign half_o = tc_i & sync_i & ((psc_q == S_MID) | (psc_q == S_LAST));
endmodule

// File: rtl/bg_sclk.sv
module bg_sclk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic toggle_i,
  output logic sclk_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sclk_q <= 1'b0;
    else if (clear_i)  sclk_q <= 1'b0;
    else if (toggle_i) sclk_q <= ~sclk_q;
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
  import bg_pkg::*;
#(
  parameter int unsigned DIV_W     = BG_DIV_W,
  parameter int unsigned ASYNC_PRE = BG_ASYNC_PRE,
  parameter int unsigned SYNC_PRE  = BG_SYNC_PRE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             div_we_i,
  input  logic             sync_mode_i,
  input  logic             master_i,
  input  logic             en_i,
  output logic             tick_o,
  output logic             sclk_o
);
  logic [DIV_W-1:0] div_q, div_nxt;
  bg_mode_e         mode_q;
  logic             mode_chg, active, restart;
  logic             tc, tc_live, wrap, half;
  logic             tick_q;

  bg_div_reg #(.W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .we_i     (div_we_i),
    .wdata_i  (div_wdata_i),
    .div_o    (div_q),
    .div_nxt_o(div_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= BG_ASYNC;
    else         mode_q <= bg_mode_e'(sync_mode_i);
  end

  assign mode_chg = (bg_mode_e'(sync_mode_i) != mode_q);
  // synchronous slave: generator output unused, keep it parked
  assign active   = en_i & (~sync_mode_i | master_i);
  assign restart  = ~active | div_we_i | mode_chg;

  bg_timer #(.W(DIV_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .reload_i (div_nxt),
    .period_i (div_q),
    .tc_o     (tc)
  );

  assign tc_live = tc & ~restart;

  bg_prescale #(.ASYNC_PRE(ASYNC_PRE), .SYNC_PRE(SYNC_PRE)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .sync_i   (sync_mode_i),
    .tc_i     (tc_live),
    .wrap_o   (wrap),
    .half_o   (half)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= wrap;
  end

  bg_sclk u_sclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart | ~sync_mode_i),
    .toggle_i(half),
    .sclk_o  (sclk_o)
  );

  assign tick_o = tick_q;
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic div_we_i,
  input logic sync_mode_i,
  input logic master_i,
  input logic en_i,
  input logic tick_o,
  input logic sclk_o
);
  a_r3_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  a_r4_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_i |=> !tick_o);

  a_r5_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && !sclk_o));

  a_r8_async_no_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_mode_i |=> !sclk_o);

  a_r9_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !master_i) |=> (!tick_o && !sclk_o));

  a_r7_sclk_falls_with_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && $past(en_i && !div_we_i && sync_mode_i && master_i)) |-> tick_o);
endmodule

bind baud_gen_top baud_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_we_i   (div_we_i),
  .sync_mode_i(sync_mode_i),
  .master_i   (master_i),
  .en_i       (en_i),
  .tick_o     (tick_o),
  .sclk_o     (sclk_o)
);

// File: tb/sim_baud_gen_top.sv
`timescale 1ns/1ps
module sim_baud_gen_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_wdata_i = '0;
  logic       div_we_i = 1'b0;
  logic       sync_mode_i = 1'b0;
  logic       master_i = 1'b1;
  logic       en_i = 1'b0;
  logic       tick_o, sclk_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  baud_gen_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_wdata_i(div_wdata_i), .div_we_i(div_we_i),
    .sync_mode_i(sync_mode_i), .master_i(master_i), .en_i(en_i),
    .tick_o(tick_o), .sclk_o(sclk_o)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic write_div(int x);
    div_wdata_i = 8'(x);
    div_we_i    = 1'b1;
    @(negedge clk_i);
    div_we_i    = 1'b0;
  endtask

  // called right after the clearing edge; checks every cycle of n periods
  task automatic run_check(int x, bit sync, int periods, string req);
    int p = (sync ? 4 : 64) * (x + 1);
    int h = 2 * (x + 1);
    for (int k = 1; k <= periods * p; k++) begin
      int ph;
      @(negedge clk_i);
      ph = k % p;
      if (ph == 1) check("R3", "tick after pulse", int'(tick_o), 0);
      else         check(req, "tick", int'(tick_o), (ph == 0) ? 1 : 0);
      check(sync ? "R7" : "R8", "sclk", int'(sclk_o), (sync && ph >= h) ? 1 : 0);
    end
  endtask

  task automatic quiet(int n, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      check(req, "tick quiet", int'(tick_o), 0);
      check(req, "sclk quiet", int'(sclk_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10", "tick in reset", int'(tick_o), 0);
    check("R10", "sclk in reset", int'(sclk_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: 16 MHz / (64*26) case, then a sweep of small divisors
    write_div(25);
    en_i = 1'b1;
    run_check(25, 1'b0, 2, "R1");
    for (int x = 0; x < 8; x++) begin
      en_i = 1'b0;
      write_div(x);
      en_i = 1'b1;
      run_check(x, 1'b0, 2, "R1");
    end

    // R2: synchronous master sweep plus the largest divisor
    en_i = 1'b0;
    sync_mode_i = 1'b1;
    @(negedge clk_i);
    for (int x = 0; x < 16; x++) begin
      en_i = 1'b0;
      write_div(x);
      en_i = 1'b1;
      run_check(x, 1'b1, 3, "R2");
    end
    en_i = 1'b0;
    write_div(255);
    en_i = 1'b1;
    run_check(255, 1'b1, 1, "R2");

    // R4: writes landing mid-period in both modes
    en_i = 1'b0;
    write_div(5);
    en_i = 1'b1;
    repeat (13) @(negedge clk_i);
    write_div(2);
    run_check(2, 1'b1, 2, "R4");
    repeat (5) @(negedge clk_i);
    write_div(9);
    run_check(9, 1'b1, 2, "R4");
    sync_mode_i = 1'b0;
    @(negedge clk_i);
    repeat (101) @(negedge clk_i);
    write_div(1);
    run_check(1, 1'b0, 2, "R4");

    // R6: mode flips mid-period
    write_div(3);
    repeat (37) @(negedge clk_i);
    sync_mode_i = 1'b1;
    @(negedge clk_i);
    run_check(3, 1'b1, 2, "R6");
    repeat (7) @(negedge clk_i);
    sync_mode_i = 1'b0;
    @(negedge clk_i);
    run_check(3, 1'b0, 1, "R6");

    // R5: disable mid-period, stay quiet, re-enable
    repeat (77) @(negedge clk_i);
    en_i = 1'b0;
    quiet(300, "R5");
    en_i = 1'b1;
    run_check(3, 1'b0, 2, "R5");

    // R9: synchronous slave parks the generator
    sync_mode_i = 1'b1;
    master_i = 1'b0;
    quiet(400, "R9");
    master_i = 1'b1;
    run_check(3, 1'b1, 2, "R9");

    // R10: divisor survives reset
    en_i = 1'b0;
    sync_mode_i = 1'b0;
    write_div(6);
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R10", "tick in reset", int'(tick_o), 0);
    check("R10", "sclk in reset", int'(sclk_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    en_i = 1'b1;
    run_check(6, 1'b0, 2, "R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule